// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the interrupt bookkeeping for one processor. It holds three bitmaps with one bit per vector: requests waiting for service, vectors now in service, and the trigger mode recorded for each vector. From these bitmaps, a task priority register and a spurious/enable register, it works out the processor priority. It raises the request line whenever a waiting vector belongs to a priority class above that priority. Priority classes are the upper four bits of a vector, and a higher vector number always ranks higher.

The processor takes a vector by pulsing `ack_valid`, and the answer appears on the response pins one cycle later. It retires the vector by writing the end-of-interrupt selector. When the retired vector was recorded as level-triggered, a one-cycle broadcast pulse carries that vector to the upstream interrupt sources.

Every strobe (`set_valid`, `wr_en`, `ack_valid`) is taken in the cycle it is high. There is no back-pressure, and no ready is returned. The two output streams (`ack_rsp_*` and `eoi_bcast_*`) are single-cycle valid pulses that the consumer must take as they come.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all three bitmaps and the task priority are zero and the spurious register holds 0x0FF. The request line is therefore low, `ppr_out` is 0, and no response or broadcast pulse appears until one is triggered.
- R2: A `set_valid` strobe marks `set_vec` as requested. It records level mode when `set_level`=1 and edge mode when `set_level`=0. The recorded mode is visible through the end-of-interrupt broadcast.
- R3: Among requested vectors, the highest-numbered one is the candidate, and vectors 0 and 255 are both reachable.
- R4: `ppr_out` equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector (0 when none is in service). Otherwise it equals that in-service upper nibble followed by 0000.
- R5: `irq_out` is high, combinationally from the current state, exactly when the enable bit is set and a candidate exists whose upper nibble is strictly above the upper nibble of `ppr_out`, or `ppr_out` is 0.
- R6: An acknowledge of a deliverable candidate moves it from requested to in service. One cycle later the pins show `ack_rsp_valid`=1, `ack_rsp_none`=0 and `ack_rsp_vec` = that vector.
- R7: An acknowledge while a candidate exists but priority blocks it returns the low 8 bits of the spurious register with `ack_rsp_none`=0, and changes no bitmap.
- R8: An acknowledge with no requested vector, or while the enable bit is clear, returns `ack_rsp_none`=1 and `ack_rsp_vec`=0.
- R9: An end-of-interrupt write (`wr_sel`=1) clears the highest in-service bit. If that vector's mode is level, `eoi_bcast_valid` pulses one cycle later with `eoi_bcast_vec` = the vector. With nothing in service, the write does nothing.
- R10: A spurious write (`wr_sel`=2) keeps `wr_data[8:0]` and ignores the rest. Bit 8 is the enable bit, and bits 7:0 are the spurious vector.
- R11: A task priority write (`wr_sel`=0) keeps `wr_data[7:0]`. Selector 3 is ignored.
- R12: Strobes in one cycle apply in a fixed order. End-of-interrupt goes first, then acknowledge, then vector set. Decisions use the state from before the cycle, so a vector set in the same cycle as its own acknowledge stays requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Vector-set strobe |
| set_vec | input | 8 | Vector to request |
| set_level | input | 1 | 1 = level mode, 0 = edge mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 task priority, 1 end-of-interrupt, 2 spurious, 3 ignored |
| wr_data | input | 16 | Write data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_none | output | 1 | Response carries no vector |
| ack_rsp_vec | output | 8 | Granted or spurious vector |
| irq_out | output | 1 | Interrupt request to the processor |
| ppr_out | output | 8 | Processor priority |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Broadcast vector |

## Verification
Directed sequences test candidates inside the same priority class as the in-service vector, and candidates one class above it. This separates the strict comparison from a greater-or-equal one. Task priority writes at, below and above a pending class separate the task priority path from the in-service path of the processor priority. Level and edge vectors are retired in nested order to show that only level modes broadcast, and a strobe of all three kinds in one cycle pins down the apply order. A long run of random strobes over a small vector set, with random priorities, is then compared cycle by cycle against a behavioural model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [1:0] {
    WR_TPR  = 2'd0,
    WR_EOI  = 2'd1,
    WR_SPUR = 2'd2,
    WR_NONE = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/irq_hi_find.sv
module irq_hi_find #(
  parameter int N = 256,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int N = 256,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_idx,
  input  logic         set_lvl,
  input  logic         ack_en,
  input  logic [W-1:0] ack_idx,
  input  logic         eoi_en,
  input  logic [W-1:0] eoi_idx,
  output logic [N-1:0] irr,
  output logic [N-1:0] isr,
  output logic [N-1:0] tmr
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic set_hit, ack_hit, eoi_hit;
    assign set_hit = set_en && (set_idx == W'(i));
    assign ack_hit = ack_en && (ack_idx == W'(i));
    assign eoi_hit = eoi_en && (eoi_idx == W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irr[i] <= 1'b0;
        isr[i] <= 1'b0;
        tmr[i] <= 1'b0;
      end else begin
        // order: end-of-interrupt, acknowledge, then set
        if (set_hit)      irr[i] <= 1'b1;
        else if (ack_hit) irr[i] <= 1'b0;
        if (ack_hit)      isr[i] <= 1'b1;
        else if (eoi_hit) isr[i] <= 1'b0;
        if (set_hit)      tmr[i] <= set_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NVEC = 256,
  parameter int WDW  = 16,
  localparam int VW  = $clog2(NVEC),
  localparam int CW  = irq_prio_pkg::CLS_W,
  localparam int SW  = VW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [VW-1:0] set_vec,
  input  logic          set_level,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [WDW-1:0] wr_data,
  input  logic          ack_valid,
  output logic          ack_rsp_valid,
  output logic          ack_rsp_none,
  output logic [VW-1:0] ack_rsp_vec,
  output logic          irq_out,
  output logic [VW-1:0] ppr_out,
  output logic          eoi_bcast_valid,
  output logic [VW-1:0] eoi_bcast_vec
);
  import irq_prio_pkg::*;

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic [VW-1:0]   tpr_q;
  logic [SW-1:0]   spur_q;

  logic          irr_any, isr_any;
  logic [VW-1:0] irr_hi, isr_hi, isr_val;
  logic [CW-1:0] isr_cls, tpr_cls, ppr_cls, cand_cls;
  logic          spur_en, deliv, ack_take, eoi_do;

  irq_hi_find #(.N(NVEC)) u_find_req (.bits(irr_q), .any(irr_any), .idx(irr_hi));
  irq_hi_find #(.N(NVEC)) u_find_svc (.bits(isr_q), .any(isr_any), .idx(isr_hi));

  always_comb begin
    isr_val  = isr_any ? isr_hi : '0;
    isr_cls  = isr_val[VW-1 -: CW];
    tpr_cls  = tpr_q[VW-1 -: CW];
    ppr_out  = (tpr_cls >= isr_cls) ? tpr_q : {isr_cls, {(VW-CW){1'b0}}};
    ppr_cls  = ppr_out[VW-1 -: CW];
    cand_cls = irr_hi[VW-1 -: CW];
    spur_en  = spur_q[SW-1];
    deliv    = irr_any && ((ppr_out == '0) || (cand_cls > ppr_cls));
    irq_out  = spur_en && deliv;
    ack_take = ack_valid && irq_out;
    eoi_do   = wr_en && (wr_sel == WR_EOI) && isr_any;
  end

  irq_vec_bank #(.N(NVEC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_valid), .set_idx(set_vec), .set_lvl(set_level),
    .ack_en(ack_take), .ack_idx(irr_hi),
    .eoi_en(eoi_do), .eoi_idx(isr_hi),
    .irr(irr_q), .isr(isr_q), .tmr(tmr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q  <= '0;
      spur_q <= {1'b0, {VW{1'b1}}};
    end else if (wr_en) begin
      if (wr_sel == WR_TPR)  tpr_q  <= wr_data[VW-1:0];
      if (wr_sel == WR_SPUR) spur_q <= wr_data[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_rsp_valid   <= 1'b0;
      ack_rsp_none    <= 1'b0;
      ack_rsp_vec     <= '0;
      eoi_bcast_valid <= 1'b0;
      eoi_bcast_vec   <= '0;
    end else begin
      ack_rsp_valid <= ack_valid;
      if (ack_valid) begin
        ack_rsp_none <= !spur_en || !irr_any;
        if (ack_take)                 ack_rsp_vec <= irr_hi;
        else if (spur_en && irr_any)  ack_rsp_vec <= spur_q[VW-1:0];
        else                          ack_rsp_vec <= '0;
      end
      eoi_bcast_valid <= eoi_do && tmr_q[isr_hi];
      eoi_bcast_vec   <= eoi_do ? isr_hi : '0;
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int NVEC = 256,
  localparam int VW = $clog2(NVEC),
  localparam int SW = VW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            set_valid,
  input logic [VW-1:0]   set_vec,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic [15:0]     wr_data,
  input logic            ack_valid,
  input logic            ack_rsp_valid,
  input logic            ack_rsp_none,
  input logic [VW-1:0]   ack_rsp_vec,
  input logic            irq_out,
  input logic [VW-1:0]   ppr_out,
  input logic            eoi_bcast_valid,
  input logic [VW-1:0]   tpr_q,
  input logic [SW-1:0]   spur_q,
  input logic [NVEC-1:0] irr_q,
  input logic [NVEC-1:0] isr_q
);
  // R2
  set_marks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> irr_q[$past(set_vec)]);

  // R4
  ppr_not_below_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ppr_out >= tpr_q);

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> spur_q[SW-1]);

  // R6
  rsp_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_rsp_valid);

  // R6
  grant_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && !ack_rsp_none && $past(irq_out)) |-> isr_q[ack_rsp_vec]);

  // R8
  disabled_ack_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !spur_q[SW-1]) |=> ack_rsp_none);

  // R9
  bcast_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(wr_en && wr_sel == 2'd1));

  // R10
  spur_keeps_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> spur_q == $past(wr_data[SW-1:0]));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack_valid(ack_valid),
  .ack_rsp_valid(ack_rsp_valid), .ack_rsp_none(ack_rsp_none),
  .ack_rsp_vec(ack_rsp_vec), .irq_out(irq_out), .ppr_out(ppr_out),
  .eoi_bcast_valid(eoi_bcast_valid), .tpr_q(tpr_q), .spur_q(spur_q),
  .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_valid = 1'b0;
  logic [7:0]  set_vec = '0;
  logic        set_level = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ack_valid = 1'b0;
  logic        ack_rsp_valid, ack_rsp_none, irq_out, eoi_bcast_valid;
  logic [7:0]  ack_rsp_vec, ppr_out, eoi_bcast_vec;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  bit m_irr[256];
  bit m_isr[256];
  bit m_tmr[256];
  int m_tpr;
  int m_spur;

  always #2.5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
    .set_level(set_level), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_valid(ack_valid), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_none(ack_rsp_none), .ack_rsp_vec(ack_rsp_vec), .irq_out(irq_out),
    .ppr_out(ppr_out), .eoi_bcast_valid(eoi_bcast_valid),
    .eoi_bcast_vec(eoi_bcast_vec)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=0x%0h expected=0x%0h", req, $time, act, exp);
    end
  endtask

  function automatic int hi_req();
    for (int i = 255; i >= 0; i--) if (m_irr[i]) return i;
    return -1;
  endfunction

  function automatic int hi_svc();
    for (int i = 255; i >= 0; i--) if (m_isr[i]) return i;
    return -1;
  endfunction

  // one clock: compare against model, advance model, compare registered outputs
  task automatic cyc();
    int hv, iv, isv, ppr, exp_vec, bc_vec;
    bit en, deliv, take, none, eoi, bc;
    hv  = hi_req();
    iv  = hi_svc();
    isv = (iv < 0) ? 0 : iv;
    ppr = ((m_tpr >> 4) >= (isv >> 4)) ? m_tpr : (isv & 'hf0);
    en  = m_spur[8];
    deliv = (hv >= 0) && (ppr == 0 || (hv >> 4) > (ppr >> 4));
    chk(irq_out == (en && deliv), "R5 irq_out", irq_out, en && deliv);
    chk(ppr_out == ppr[7:0], "R4 ppr_out", ppr_out, ppr);
    take = ack_valid && en && deliv;
    none = !en || hv < 0;
    exp_vec = take ? hv : (none ? 0 : (m_spur & 'hff));
    eoi = wr_en && wr_sel == 2'd1 && iv >= 0;
    bc = eoi && m_tmr[isv];
    bc_vec = isv;
    if (eoi) m_isr[iv] = 0;
    if (take) begin m_irr[hv] = 0; m_isr[hv] = 1; end
    if (set_valid) begin m_irr[set_vec] = 1; m_tmr[set_vec] = set_level; end
    if (wr_en && wr_sel == 2'd0) m_tpr = wr_data & 'hff;
    if (wr_en && wr_sel == 2'd2) m_spur = wr_data & 'h1ff;
    begin
      bit av;
      av = ack_valid;
      @(posedge clk);
      #1;
      chk(ack_rsp_valid == av, "R6 ack_rsp_valid", ack_rsp_valid, av);
      if (av) begin
        chk(ack_rsp_none == none, "R8 ack_rsp_none", ack_rsp_none, none);
        chk(ack_rsp_vec == exp_vec[7:0], "R7 ack_rsp_vec", ack_rsp_vec, exp_vec);
      end
      chk(eoi_bcast_valid == bc, "R9 eoi_bcast_valid", eoi_bcast_valid, bc);
      if (bc) chk(eoi_bcast_vec == bc_vec[7:0], "R9 eoi_bcast_vec", eoi_bcast_vec, bc_vec);
    end
    set_valid = 0; wr_en = 0; ack_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_set(int v, bit lvl);
    set_valid = 1; set_vec = v[7:0]; set_level = lvl; cyc();
  endtask
  task automatic do_wr(int sel, int d);
    wr_en = 1; wr_sel = sel[1:0]; wr_data = d[15:0]; cyc();
  endtask
  task automatic do_ack();
    ack_valid = 1; cyc();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_tmr[i] = 0; end
    m_tpr = 0;
    m_spur = 'h0ff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state seen on the idle cycle
    cyc();
    // R8 / R10: pending vector but disabled, ack returns none, irq low
    do_set('h40, 0);
    do_ack();
    // R10: only bits 8:0 kept -> enable set, spurious vector 0x3F
    do_wr(2, 'hFF3F);
    // R2 / R3: highest pending wins
    do_set('h45, 0);
    do_set('h30, 1);
    do_ack();                 // expect 0x45, ppr 0x40
    // R7: 0x40 in same class as in-service -> spurious
    do_ack();
    // R5: class above in-service
    do_set('h90, 1);
    do_ack();                 // 0x90
    // R9: level broadcast, then edge silent
    do_wr(1, 0);
    do_wr(1, 0);
    // R11: task priority keeps low 8 bits
    do_wr(0, 'hAB57);         // tpr 0x57 blocks 0x40, 0x30
    do_ack();
    do_wr(0, 'h003F);         // 0x40 class 4 > 3
    do_wr(3, 'h00FF);         // R11: selector 3 ignored
    do_ack();                 // 0x40
    do_wr(1, 0);              // retire 0x40, edge
    do_wr(1, 0);              // R9: nothing in service
    do_wr(0, 0);
    // R12: ack of 0x30 and re-set of 0x30 as edge in the same cycle
    ack_valid = 1; set_valid = 1; set_vec = 'h30; set_level = 0; cyc();
    do_set('hFF, 1);          // R3: vector 255
    // R12: end-of-interrupt, acknowledge and set together
    wr_en = 1; wr_sel = 1; ack_valid = 1; set_valid = 1; set_vec = 'h00; set_level = 1; cyc();
    do_wr(1, 0);
    do_wr(1, 0);
    do_ack();                 // R3: 0x30 again or vector 0 per model
    do_ack();
    do_wr(1, 0);
    do_wr(1, 0);
    // random strobes over a small vector set against the model
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      set_valid = (r < 35);
      set_vec   = 8'($urandom_range(0, 15) * 16 + $urandom_range(0, 1) * 15);
      set_level = $urandom_range(0, 1);
      ack_valid = ($urandom_range(0, 99) < 30);
      wr_en     = ($urandom_range(0, 99) < 30);
      r = $urandom_range(0, 9);
      wr_sel    = (r < 6) ? 2'd1 : (r < 8) ? 2'd0 : (r < 9) ? 2'd2 : 2'd3;
      wr_data   = (wr_sel == 2'd2) ? 16'($urandom_range(0, 3) == 0 ? 'h0A5 : 'h1A5)
                                   : 16'($urandom_range(0, 65535) & 'hF0F0);
      cyc();
    end
    done = 1;
    finish_run();
  end
endmodule